// File: doc/BRIEF.md
# Normalised 3x3 Gradient Edge Filter

This block turns a raster stream of 8-bit grayscale pixels into an 8-bit edge-strength image. Pixels arrive one row after another; two stored rows plus the incoming pixel give a 3x3 neighbourhood. From it the block takes a left-to-right difference and a top-to-bottom difference with flat (all-ones) weights, and combines them into a gradient magnitude. Each interior magnitude is written to an on-chip frame store, and the largest one in the frame is tracked.

Once the whole frame is in, a second pass reads the store back in raster order. It scales every magnitude so that the frame's strongest edge maps to 255 and sends the result out with valid and last flags. While this pass runs the input side is closed. The frame geometry is a pair of parameters: the default is 32x32 so the block elaborates small, and the production setting is 128 columns by 128 rows.

Top module: `gradient_edge_filter`

## Requirements
- R1: `in_ready` is 1 from reset and throughout frame loading. It drops after the edge that accepts the last pixel of a frame and rises again only after the cycle in which `out_last` is shown. Pixels offered while `in_ready` is 0 are ignored.
- R2: For an interior pixel, the horizontal gradient is the sum of the three right-hand neighbours minus the sum of the three left-hand neighbours. The vertical gradient is the sum of the row below minus the sum of the row above.
- R3: The magnitude of an interior pixel is floor(sqrt(gx*gx + gy*gy)), in the range 0 to 1081.
- R4: Each interior output is floor(magnitude * 255 / peak), where peak is the largest magnitude in the same frame.
- R5: Every pixel in row 0, the last row, column 0 or the last column outputs 0.
- R6: When the frame peak is 0, every output pixel is 0.
- R7: Every pixel whose magnitude equals a non-zero frame peak outputs exactly 255.
- R8: Each frame produces exactly ROWS*COLS output beats in raster order, on consecutive cycles. `out_last` is 1 only on the final beat.
- R9: The first output beat is shown after the third rising edge that follows the edge accepting the frame's last pixel.
- R10: Idle cycles (`in_valid` low) anywhere inside a frame do not change its output.
- R11: The peak is cleared between frames, so each frame is normalised only against its own magnitudes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_pix | input | 8 | Input grayscale pixel, raster order |
| in_ready | output | 1 | Input side open (frame loading phase) |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 8 | Normalised edge strength |
| out_last | output | 1 | Final pixel of the output frame |

## Verification
The case hardest to reach from the ports is the handover between frames. Here the peak must be cleared, the line buffers still hold the previous frame's rows, and the source may keep `in_valid` high while the block is closed. The stimulus builds this case directly. A frame with a large peak is followed by one with a small peak and then by a flat frame. One frame is fed with random idle gaps and then with junk pixels held on the input through the whole emission pass. The next frame's expected image shows that no junk pixel leaked in.

// File: rtl/gef_pkg.sv
package gef_pkg;
  localparam int PIX_W   = 8;
  localparam int SUM_W   = PIX_W + 2;     // sum of three pixels
  localparam int MAG_W   = 11;            // root of 2*765^2 fits 11 bits
  localparam int SQ_W    = 2 * MAG_W;     // sum of squares
  localparam int NORM_W  = MAG_W + PIX_W; // mag * 255
  localparam int OUT_MAX = 255;

  typedef enum logic [1:0] {ST_LOAD, ST_FLUSH, ST_EMIT} phase_t;

  function automatic logic [SUM_W-1:0] abs_diff(input logic [SUM_W-1:0] a,
                                                input logic [SUM_W-1:0] b);
    return (a >= b) ? a - b : b - a;
  endfunction

  // Bit-by-bit floor square root.
  function automatic logic [MAG_W-1:0] int_sqrt(input logic [SQ_W-1:0] v);
    logic [MAG_W-1:0] root;
    logic [MAG_W-1:0] trial;
    logic [SQ_W-1:0]  sq;
    root = '0;
    for (int b = MAG_W - 1; b >= 0; b--) begin
      trial = root | (MAG_W'(1) << b);
      sq    = SQ_W'(trial) * SQ_W'(trial);
      if (sq <= v) root = trial;
    end
    return root;
  endfunction

  // floor(mag * 255 / peak); zero peak gives zero without dividing.
  function automatic logic [PIX_W-1:0] norm_pix(input logic [MAG_W-1:0] mag,
                                                input logic [MAG_W-1:0] peak);
    logic [NORM_W-1:0] num;
    logic [NORM_W-1:0] quo;
    if (peak == '0) return '0;
    num = NORM_W'(mag) * NORM_W'(OUT_MAX);
    quo = num / NORM_W'(peak);
    return quo[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/gef_window.sv
module gef_window
  import gef_pkg::*;
#(
  parameter int COLS  = 32,
  parameter int COL_W = $clog2(COLS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic [COL_W-1:0]            col,
  input  logic [PIX_W-1:0]            pix,
  output logic [2:0][2:0][PIX_W-1:0]  win   // [row][column], 0 = top / left
);
  logic [PIX_W-1:0] row_up1 [COLS];  // one row above the incoming pixel
  logic [PIX_W-1:0] row_up2 [COLS];  // two rows above
  logic [2:0][PIX_W-1:0] col_new, col_m1, col_m2;

  assign col_new = {pix, row_up1[col], row_up2[col]};

  always_ff @(posedge clk) begin
    if (push) begin
      row_up2[col] <= row_up1[col];
      row_up1[col] <= pix;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_m1 <= '0;
      col_m2 <= '0;
    end else if (push) begin
      col_m2 <= col_m1;
      col_m1 <= col_new;
    end
  end

  for (genvar r = 0; r < 3; r++) begin : g_row
    assign win[r][0] = col_m2[r];
    assign win[r][1] = col_m1[r];
    assign win[r][2] = col_new[r];
  end
endmodule

// File: rtl/gef_gradient.sv
module gef_gradient
  import gef_pkg::*;
(
  input  logic [2:0][2:0][PIX_W-1:0] win,
  output logic [MAG_W-1:0]           mag
);
  logic [SUM_W-1:0] sum_l, sum_r, sum_t, sum_b;
  logic [SUM_W-1:0] gx_abs, gy_abs;
  logic [SQ_W-1:0]  sq;

  always_comb begin
    sum_l = '0;
    sum_r = '0;
    sum_t = '0;
    sum_b = '0;
    for (int k = 0; k < 3; k++) begin
      sum_l = sum_l + SUM_W'(win[k][0]);
      sum_r = sum_r + SUM_W'(win[k][2]);
      sum_t = sum_t + SUM_W'(win[0][k]);
      sum_b = sum_b + SUM_W'(win[2][k]);
    end
  end

  assign gx_abs = abs_diff(sum_r, sum_l);
  assign gy_abs = abs_diff(sum_b, sum_t);
  assign sq     = SQ_W'(gx_abs) * SQ_W'(gx_abs) + SQ_W'(gy_abs) * SQ_W'(gy_abs);
  assign mag    = int_sqrt(sq);

  // R3: the root lies between floor bounds of the sum of squares
  always_comb begin
    a_r3_root_bounds: assert ((SQ_W+2)'(mag) * (SQ_W+2)'(mag) <= (SQ_W+2)'(sq) &&
                              ((SQ_W+2)'(mag) + 1) * ((SQ_W+2)'(mag) + 1) > (SQ_W+2)'(sq));
  end
endmodule

// File: rtl/gef_frame_store.sv
module gef_frame_store
  import gef_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [MAG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [MAG_W-1:0]  rd_data
);
  logic [MAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/gradient_edge_filter.sv
module gradient_edge_filter
  import gef_pkg::*;
#(
  parameter int COLS = 32,
  parameter int ROWS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_pix,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_pix,
  output logic       out_last
);
  localparam int PIXELS    = COLS * ROWS;
  localparam int ADDR_W    = $clog2(PIXELS);
  localparam int COL_W     = $clog2(COLS);
  localparam int ROW_W     = $clog2(ROWS);
  localparam int MAG_LIMIT = 1081;

  phase_t phase;

  // load side
  logic [COL_W-1:0]  in_col;
  logic [ROW_W-1:0]  in_row;
  logic [ADDR_W-1:0] in_addr;
  logic              accept, frame_in_done, center_ok;
  logic [2:0][2:0][PIX_W-1:0] win;
  logic [MAG_W-1:0]  mag_now;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [MAG_W-1:0]  wr_mag;
  logic [MAG_W-1:0]  peak;

  // emit side
  logic              issue_on;
  logic [ADDR_W-1:0] oaddr;
  logic [COL_W-1:0]  ocol;
  logic [ROW_W-1:0]  orow;
  logic              on_border, issue_last;
  logic              s1_v, s1_edge, s1_last;
  logic [MAG_W-1:0]  rd_mag;
  logic              frame_out_done;

  assign in_ready       = (phase == ST_LOAD);
  assign accept         = in_valid && in_ready;
  assign frame_in_done  = accept && (in_addr == ADDR_W'(PIXELS - 1));
  assign center_ok      = (in_row >= ROW_W'(2)) && (in_col >= COL_W'(2));
  assign frame_out_done = out_valid && out_last;
  assign on_border      = (orow == '0) || (orow == ROW_W'(ROWS - 1)) ||
                          (ocol == '0) || (ocol == COL_W'(COLS - 1));
  assign issue_last     = (oaddr == ADDR_W'(PIXELS - 1));

  gef_window #(.COLS(COLS), .COL_W(COL_W)) u_window (
    .clk(clk), .rst_n(rst_n), .push(accept), .col(in_col), .pix(in_pix), .win(win)
  );

  gef_gradient u_gradient (.win(win), .mag(mag_now));

  gef_frame_store #(.DEPTH(PIXELS), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_mag),
    .rd_addr(oaddr), .rd_data(rd_mag)
  );

  // phase sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) phase <= ST_LOAD;
    else begin
      case (phase)
        ST_LOAD:  if (frame_in_done) phase <= ST_FLUSH;
        ST_FLUSH: phase <= ST_EMIT;
        ST_EMIT:  if (frame_out_done) phase <= ST_LOAD;
        default:  phase <= ST_LOAD;
      endcase
    end
  end

  // raster position of the incoming pixel; the window centre trails by one row and column
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_col  <= '0;
      in_row  <= '0;
      in_addr <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_mag  <= '0;
    end else begin
      wr_en <= accept && center_ok;
      if (accept) begin
        wr_addr <= in_addr - ADDR_W'(COLS + 1);
        wr_mag  <= mag_now;
        in_addr <= frame_in_done ? '0 : in_addr + 1'b1;
        if (in_col == COL_W'(COLS - 1)) begin
          in_col <= '0;
          in_row <= (in_row == ROW_W'(ROWS - 1)) ? '0 : in_row + 1'b1;
        end else begin
          in_col <= in_col + 1'b1;
        end
      end
    end
  end

  // frame peak, cleared as the last output beat leaves
  always_ff @(posedge clk) begin
    if (!rst_n)                         peak <= '0;
    else if (frame_out_done)            peak <= '0;
    else if (wr_en && (wr_mag > peak))  peak <= wr_mag;
  end

  // second pass: address issue, then read stage, then scaled output
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_on <= 1'b0;
      oaddr    <= '0;
      ocol     <= '0;
      orow     <= '0;
      s1_v     <= 1'b0;
      s1_edge  <= 1'b0;
      s1_last  <= 1'b0;
      out_valid <= 1'b0;
      out_pix  <= '0;
      out_last <= 1'b0;
    end else begin
      if (phase == ST_FLUSH) begin
        issue_on <= 1'b1;
        oaddr    <= '0;
        ocol     <= '0;
        orow     <= '0;
      end else if (issue_on) begin
        oaddr <= oaddr + 1'b1;
        if (ocol == COL_W'(COLS - 1)) begin
          ocol <= '0;
          orow <= orow + 1'b1;
        end else begin
          ocol <= ocol + 1'b1;
        end
        if (issue_last) issue_on <= 1'b0;
      end
      s1_v      <= issue_on;
      s1_edge   <= on_border;
      s1_last   <= issue_on && issue_last;
      out_valid <= s1_v;
      out_last  <= s1_last;
      out_pix   <= (s1_v && !s1_edge) ? norm_pix(rd_mag, peak) : '0;
    end
  end

  // R1: input side stays closed while results leave
  a_r1_closed_while_emitting: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R8: last only on a valid beat
  a_r8_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R8: beats of one frame are back to back
  a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |=> out_valid);

  // R6: a zero peak yields zero pixels
  a_r6_flat_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (peak == '0)) |-> (out_pix == '0));

  // R3: stored magnitudes stay inside the reachable range
  a_r3_mag_limit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_mag <= MAG_LIMIT[MAG_W-1:0]));

  // R11: peak only falls at the end of a frame
  a_r11_peak_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_out_done) |-> (peak >= $past(peak)));
endmodule

// File: tb/tb_gradient_edge_filter.sv
module tb_gradient_edge_filter;
  localparam int COLS   = 32;
  localparam int ROWS   = 32;
  localparam int PIXELS = COLS * ROWS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_pix = '0;
  logic       in_ready, out_valid, out_last;
  logic [7:0] out_pix;

  always #2 clk = ~clk;  // 4 ns period

  gradient_edge_filter #(.COLS(COLS), .ROWS(ROWS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_ready(in_ready), .out_valid(out_valid), .out_pix(out_pix), .out_last(out_last)
  );

  typedef struct { int pix; bit last; string tag; } exp_t;
  exp_t sb[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_cyc = 0;
  bit want_lat = 0;
  int frame_beats = 0;
  int full_hits = 0;
  int img [ROWS][COLS];
  int rmag [ROWS][COLS];

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int root_floor(int s);
    int m;
    m = int'($floor($sqrt(real'(s))));
    while (m * m > s) m--;
    while ((m + 1) * (m + 1) <= s) m++;
    return m;
  endfunction

  function automatic bit is_edge(int r, int c);
    return (r == 0) || (c == 0) || (r == ROWS - 1) || (c == COLS - 1);
  endfunction

  // Reference: explicit kernel convolution, peak search, integer scaling.
  task automatic build_expect();
    int peak = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        rmag[r][c] = 0;
        if (!is_edge(r, c)) begin
          int gx = 0;
          int gy = 0;
          for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++) begin
              gx += dc * img[r + dr][c + dc];  // R2: columns weighted -1 0 +1
              gy += dr * img[r + dr][c + dc];  // R2: rows weighted -1 0 +1
            end
          rmag[r][c] = root_floor(gx * gx + gy * gy);  // R3
          if (rmag[r][c] > peak) peak = rmag[r][c];
        end
      end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        exp_t e;
        e.pix  = (peak == 0) ? 0 : (rmag[r][c] * 255) / peak;
        e.last = (r == ROWS - 1) && (c == COLS - 1);
        if (is_edge(r, c))     e.tag = "R5";
        else if (peak == 0)    e.tag = "R6";
        else if (e.pix == 255) e.tag = "R7";
        else                   e.tag = "R2 R3 R4";
        sb.push_back(e);
      end
  endtask

  // Driver: pushes the expected frame, then feeds the pixels.
  task automatic drive_frame(int gap_pct, bit junk_after, string tag);
    build_expect();
    frame_beats = 0;
    full_hits = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        @(negedge clk);
        while (!in_ready || (gap_pct > 0 && $urandom_range(0, 99) < gap_pct)) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
        in_valid = 1'b1;
        in_pix   = img[r][c][7:0];
        last_cyc = cyc;
      end
    want_lat = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R1", "ready after final pixel", int'(in_ready), 0);
    in_valid = junk_after;  // R1: junk held during emission must be ignored
    in_pix   = 8'hFF;
    while (sb.size() != 0 || !in_ready) @(negedge clk);
    in_valid = 1'b0;
    check(frame_beats == PIXELS, tag, "beats in frame", frame_beats, PIXELS);
  endtask

  // Monitor: pops and compares each output beat.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      if (sb.size() == 0) begin
        check(1'b0, "R8", "beat with nothing expected", int'(out_pix), -1);
      end else begin
        e = sb.pop_front();
        frame_beats++;
        if (out_pix == 8'd255) full_hits++;
        check(int'(out_pix) == e.pix, e.tag, "pixel", int'(out_pix), e.pix);
        check(out_last == e.last, "R8", "last flag", int'(out_last), int'(e.last));
        if (want_lat) begin
          check(cyc - last_cyc == 4, "R9", "first-beat latency", cyc - last_cyc, 4);
          want_lat = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired, beats left", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R8", "no output after reset", int'(out_valid), 0);

    // random texture, continuous input
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) img[r][c] = $urandom_range(0, 255);
    drive_frame(0, 1'b0, "R8");

    // R10: random idle gaps; R1: junk afterwards
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) img[r][c] = $urandom_range(0, 255);
    drive_frame(35, 1'b1, "R10");

    // vertical step: only the horizontal gradient is non-zero (R2)
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) img[r][c] = (c < COLS / 2) ? 0 : 255;
    drive_frame(0, 1'b0, "R2");

    // R11: a small lone spot after a strong frame must still reach 255
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) img[r][c] = 0;
    img[10][12] = 9;
    drive_frame(0, 1'b0, "R7");
    check(full_hits > 0, "R11", "full-scale beats after strong frame", full_hits, 1);

    // horizontal ramp with a bright band: vertical gradient dominates
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) img[r][c] = (r >= 20 && r < 23) ? 250 : r * 3;
    drive_frame(10, 1'b1, "R8");

    // R6: flat frame has zero peak
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) img[r][c] = 77;
    drive_frame(0, 1'b0, "R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule